// File: doc/BRIEF.md
# Burst Power-Loop Switch Sequencer

This block sequences the switches and driver enables of a two-band transmit power control loop that runs in bursts. The analog loop (sensor amplifier, integrator, filter, threshold comparator) lives outside. This block only decides which switches are closed, which output driver is powered, and which driver output is clamped to ground. All timing is counted in cycles of the block clock.

A burst starts when the enable input rises. The block captures the band selection at that moment and holds it until the enable input falls. It closes the sensor sample switch and the prebias force switch for a fixed sampling phase. It then waits for a ramp-detect strobe from an external comparator. The strobe passes through a synchronizer, and only a rising edge seen after sampling counts. On a detected ramp, the output leaves prebias for the home level. After a fixed handover time, the selected feedback switch opens and the loop-transfer switch closes. Dropping the enable input returns the block to idle on the next clock edge.

Top module: `burst_switch_seq`

## Requirements
- R1: With the enable input low, and after reset, the block is idle. The phase reads 0. The sample and prebias switches are closed. The home, transfer and both feedback switches are open. Both drivers are off, and both driver outputs are clamped to ground.
- R2: The band input is captured on the clock edge that starts a burst. Changes on it during the burst have no effect on any output.
- R3: Band 0 uses index 0 of `fb_sw`, `drv_on` and `drv_gnd`; band 1 uses index 1. The selected driver is on and unclamped. The other driver is off, clamped, and its feedback switch is open.
- R4: On the first edge where enable is high after being low, the block enters phase 1 (sampling). In that phase the sample, prebias and selected feedback switches are closed, and the home and transfer switches are open.
- R5: Sampling lasts exactly SAMPLE_CYC cycles. The block then enters phase 2 (wait for ramp), where the sample switch is open, and the prebias and selected feedback switches stay closed.
- R6: The ramp strobe passes through SYNC_STAGES flip-flops. A rising edge of the synchronized strobe during phase 2 moves the block to phase 3 (home) SYNC_STAGES+1 cycles after the input rises. In phase 3, prebias is open and home is closed, and the feedback switch stays closed.
- R7: Rising edges of the synchronized strobe before phase 2 are ignored. A strobe level that is still high from the sampling phase does not trigger detection.
- R8: Phase 3 lasts exactly HAND_CYC cycles, however long the wait for the ramp was. The block then enters phase 4 (closed loop): feedback open, transfer closed, home closed.
- R9: Enable low at a clock edge returns the block to the idle state of R1 on that edge, from any phase.
- R10: At most one feedback switch and at most one driver are active at any time. Each driver's ground clamp is the complement of its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst | input | 1 | synchronous active-high reset |
| pwr_en | input | 1 | burst enable |
| band_sel | input | 1 | band selection, captured at burst start |
| ramp_hit | input | 1 | asynchronous ramp-detect strobe |
| phase_o | output | 3 | phase: 0 idle, 1 sampling, 2 wait, 3 home, 4 closed loop |
| smp_sw | output | 1 | sensor sample switch closed |
| pre_sw | output | 1 | prebias force switch closed |
| home_sw | output | 1 | home-level switch closed |
| xfer_sw | output | 1 | loop-transfer switch closed |
| fb_sw | output | 2 | per-band feedback switch closed |
| drv_on | output | 2 | per-band driver powered |
| drv_gnd | output | 2 | per-band driver output clamped to ground |

## Verification
The bench holds the ramp strobe high through sampling. A design that acts on the strobe level, or one that honours edges during sampling, would skip the wait phase too early. It flips the band input mid-burst, which a design without a capture register would follow by swapping drivers. It runs one burst with a prompt ramp and one with a late single-cycle pulse, and expects the same home duration in both. A handover timer that started at the burst edge would shorten the second burst. Last, it drops the enable during sampling to show the return to idle in one edge.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SAMPLE = 3'd1,
    PH_WAIT   = 3'd2,
    PH_HOME   = 3'd3,
    PH_LOOP   = 3'd4
  } phase_e;

  typedef struct packed {
    logic       smp;
    logic       pre;
    logic       home;
    logic       xfer;
    logic [1:0] fb;
    logic [1:0] drv;
    logic [1:0] gnd;
  } sw_t;

  // switch pattern for a phase and a captured band
  function automatic sw_t sw_decode(phase_e ph, logic band);
    sw_t s;
    s      = '0;
    s.gnd  = 2'b11;
    if (ph == PH_IDLE) begin
      s.smp = 1'b1;
      s.pre = 1'b1;
    end else begin
      s.drv[band] = 1'b1;
      s.gnd[band] = 1'b0;
      case (ph)
        PH_SAMPLE: begin s.smp = 1'b1; s.pre = 1'b1; s.fb[band] = 1'b1; end
        PH_WAIT:   begin s.pre = 1'b1; s.fb[band] = 1'b1; end
        PH_HOME:   begin s.home = 1'b1; s.fb[band] = 1'b1; end
        PH_LOOP:   begin s.home = 1'b1; s.xfer = 1'b1; end
        default:   ;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/bss_sync.sv
module bss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], d};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R6: a synchronized edge reflects the input STAGES cycles earlier
  a_r6_sync_delay: assert property (@(posedge clk) disable iff (rst)
    rise |-> $past(d, STAGES));
endmodule

// File: rtl/bss_timer.sv
module bss_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bss_fsm.sv
module bss_fsm
  import bss_pkg::*;
#(
  parameter int SAMPLE_CYC = 8,
  parameter int HAND_CYC   = 5,
  parameter int CW         = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_en,
  input  logic          band_sel,
  input  logic          det,
  input  logic [CW-1:0] cnt,
  output phase_e        phase,
  output phase_e        nxt,
  output logic          band_nx,
  output logic          clr
);
  localparam logic [CW-1:0] SMP_LAST = CW'(SAMPLE_CYC - 1);
  localparam logic [CW-1:0] HND_LAST = CW'(HAND_CYC - 1);

  logic en_q, band_q, start;

  assign start = pwr_en & ~en_q & (phase == PH_IDLE);

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE:   if (start) nxt = PH_SAMPLE;
      PH_SAMPLE: if (cnt == SMP_LAST) nxt = PH_WAIT;
      PH_WAIT:   if (det) nxt = PH_HOME;
      PH_HOME:   if (cnt == HND_LAST) nxt = PH_LOOP;
      default:   nxt = phase;
    endcase
    if (!pwr_en) nxt = PH_IDLE;
  end

  assign clr     = (nxt != phase);
  assign band_nx = start ? band_sel : band_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      en_q   <= 1'b0;
      band_q <= 1'b0;
    end else begin
      phase  <= nxt;
      en_q   <= pwr_en;
      band_q <= band_nx;
    end
  end

  // R9: enable low always lands in idle
  a_r9_drop_to_idle: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> phase == PH_IDLE);
  // R2: captured band holds while a burst is running
  a_r2_band_hold: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> (phase == PH_IDLE || $stable(band_q)));
  // R6: a detected ramp in the wait phase moves to home
  a_r6_det_to_home: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT && det && pwr_en) |=> phase == PH_HOME);
  // R8: home ends after the fixed handover count
  a_r8_handover: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOME && cnt == HND_LAST && pwr_en) |=> phase == PH_LOOP);
  // R5: sampling ends after its fixed count
  a_r5_sample_exit: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SAMPLE && cnt == SMP_LAST && pwr_en) |=> phase == PH_WAIT);
endmodule

// File: rtl/burst_switch_seq.sv
module burst_switch_seq
  import bss_pkg::*;
#(
  parameter int SAMPLE_CYC  = 8,
  parameter int HAND_CYC    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_en,
  input  logic       band_sel,
  input  logic       ramp_hit,
  output logic [2:0] phase_o,
  output logic       smp_sw,
  output logic       pre_sw,
  output logic       home_sw,
  output logic       xfer_sw,
  output logic [1:0] fb_sw,
  output logic [1:0] drv_on,
  output logic [1:0] drv_gnd
);
  localparam int MAXC = (SAMPLE_CYC > HAND_CYC) ? SAMPLE_CYC : HAND_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          det, clr, band_nx;
  logic [CW-1:0] cnt;
  phase_e        phase, nxt;
  sw_t           sw_q;

  bss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(ramp_hit), .rise(det));

  bss_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .clr(clr), .cnt(cnt));

  bss_fsm #(.SAMPLE_CYC(SAMPLE_CYC), .HAND_CYC(HAND_CYC), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .band_sel(band_sel), .det(det),
    .cnt(cnt), .phase(phase), .nxt(nxt), .band_nx(band_nx), .clr(clr));

  // outputs registered from the next-state so they line up with the phase
  always_ff @(posedge clk) begin
    if (rst) sw_q <= sw_decode(PH_IDLE, 1'b0);
    else     sw_q <= sw_decode(nxt, band_nx);
  end

  assign phase_o = phase;
  assign smp_sw  = sw_q.smp;
  assign pre_sw  = sw_q.pre;
  assign home_sw = sw_q.home;
  assign xfer_sw = sw_q.xfer;
  assign fb_sw   = sw_q.fb;
  assign drv_on  = sw_q.drv;
  assign drv_gnd = sw_q.gnd;

  // R10: one band at a time, clamps complement enables
  a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fb_sw) && $onehot0(drv_on) && (drv_gnd == ~drv_on));
  // R6: prebias release always hands over to home with feedback still closed
  a_r6_pre_to_home: assert property (@(posedge clk) disable iff (rst)
    ($fell(pre_sw) && pwr_en) |-> (home_sw && fb_sw != 2'b00));
  // R1: idle keeps both drivers clamped
  a_r1_idle_clamp: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd0) |-> (drv_gnd == 2'b11 && !home_sw && !xfer_sw));
endmodule

// File: tb/test_burst_switch_seq.sv
module test_burst_switch_seq;
  localparam int SAMPLE_CYC = 8;
  localparam int HAND_CYC   = 5;

  logic clk = 0, rst = 1, pwr_en = 0, band_sel = 0, ramp_hit = 0;
  logic [2:0] phase_o;
  logic smp_sw, pre_sw, home_sw, xfer_sw;
  logic [1:0] fb_sw, drv_on, drv_gnd;

  burst_switch_seq #(.SAMPLE_CYC(SAMPLE_CYC), .HAND_CYC(HAND_CYC), .SYNC_STAGES(2))
  i_burst_switch_seq (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .band_sel(band_sel), .ramp_hit(ramp_hit),
    .phase_o(phase_o), .smp_sw(smp_sw), .pre_sw(pre_sw), .home_sw(home_sw),
    .xfer_sw(xfer_sw), .fb_sw(fb_sw), .drv_on(drv_on), .drv_gnd(drv_gnd));

  always #10 clk = ~clk;

  typedef struct { string tag; logic [12:0] exp; } item_t;
  item_t sb[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // expected vector {phase, smp, pre, home, xfer, fb, drv, gnd} from the requirements
  function automatic logic [12:0] ev(int ph, logic b);
    logic s = 0, p = 0, h = 0, x = 0;
    logic [1:0] f = 0, d = 0;
    if (ph == 0) begin s = 1; p = 1; end
    else begin
      d[b] = 1;
      if (ph == 1) begin s = 1; p = 1; f[b] = 1; end
      if (ph == 2) begin p = 1; f[b] = 1; end
      if (ph == 3) begin h = 1; f[b] = 1; end
      if (ph == 4) begin h = 1; x = 1; end
    end
    return {3'(ph), s, p, h, x, f, d, ~d};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_st(string tag, int ph, logic b);
    item_t it;
    it.tag = tag;
    it.exp = ev(ph, b);
    sb.push_back(it);
  endtask

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [12:0] act;
      it  = sb.pop_front();
      act = {phase_o, smp_sw, pre_sw, home_sw, xfer_sw, fb_sw, drv_on, drv_gnd};
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 0;
    tick(1); expect_st("R1 idle after reset", 0, 0);

    // burst A, band 0, strobe held through sampling
    pwr_en = 1;
    tick(1); expect_st("R4 sampling start band0", 1, 0);
    band_sel = 1;
    ramp_hit = 1;
    tick(SAMPLE_CYC - 1); expect_st("R5 still sampling", 1, 0);
    tick(1); expect_st("R5 wait entered", 2, 0);
    tick(4); expect_st("R7 held strobe ignored", 2, 0);
    ramp_hit = 0;
    tick(2);
    ramp_hit = 1;
    tick(2); expect_st("R6 not yet detected", 2, 0);
    tick(1); expect_st("R6 home after sync", 3, 0);
    ramp_hit = 0;
    tick(HAND_CYC - 1); expect_st("R8 still home", 3, 0);
    tick(1); expect_st("R8 R2 closed loop band0", 4, 0);
    pwr_en = 0;
    tick(1); expect_st("R9 idle from loop", 0, 0);

    // burst B, band 1, late one-cycle strobe
    tick(2);
    pwr_en = 1;
    tick(1); expect_st("R3 sampling band1", 1, 1);
    tick(SAMPLE_CYC); expect_st("R3 wait band1", 2, 1);
    tick(10); expect_st("R6 no strobe keeps wait", 2, 1);
    ramp_hit = 1;
    tick(1);
    ramp_hit = 0;
    tick(1); expect_st("R6 pulse in flight", 2, 1);
    tick(1); expect_st("R6 home band1", 3, 1);
    tick(HAND_CYC - 1); expect_st("R8 fixed handover late ramp", 3, 1);
    tick(1); expect_st("R8 closed loop band1", 4, 1);
    band_sel = 0;
    tick(3); expect_st("R2 band change ignored", 4, 1);
    pwr_en = 0;
    tick(1); expect_st("R9 idle band1 end", 0, 0);

    // burst C, abort during sampling
    tick(2);
    pwr_en = 1;
    tick(3); expect_st("R10 sampling band0", 1, 0);
    pwr_en = 0;
    tick(1); expect_st("R9 abort sampling", 0, 0);
    tick(3); expect_st("R1 idle stays", 0, 0);

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule